// File: doc/BRIEF.md
# Queue-Occupancy Attack/Decay Frequency Governor

This block steers the clock frequency of one clock domain from the occupancy of the queue that feeds that domain. On every cycle it adds the queue's entry count to a running sum. When the interval-end strobe arrives, it compares this interval's sum with the sum from the interval before. A large enough swing in either direction is an "attack", which moves the frequency level by a programmed step toward the demand. Without such a swing the level drifts slowly downward by a smaller decay step.

Any reduction of the level that the governor chooses on its own, whether a downward attack or a decay, is allowed only while the performance loss reported for the last interval is below a programmed limit. A level that stays pinned at the top or the bottom of its range for a programmed number of consecutive intervals is pushed back off that limit by a forced attack. Each domain gets its own instance, and instances share no state. The output is a level index whose default range is 0 to 319. Level 0 stands for the slowest clock and level 319 for the fastest.

Top module: `qgov_ctrl`

## Requirements
- R1: While reset is asserted (rstN low), `level` equals the maximum level (319 by default) and `levelValid` is 0.
- R2: The interval sum is the saturating total of `occupancy` over every cycle since the previous strobe, including the strobe cycle itself. If this sum exceeds the previous interval's sum by more than `devThresh`, the level rises by `reactStep`. Before the first strobe the previous sum counts as 0.
- R3: If the previous sum exceeds this interval's sum by more than `devThresh` and `perfLoss < perfThresh`, the level falls by `reactStep`.
- R4: If neither swing exceeds `devThresh` and `perfLoss < perfThresh`, the level falls by `decayStep`.
- R5: If `perfLoss >= perfThresh` and no forced attack fires, the level does not fall: a downward attack or a decay leaves it unchanged.
- R6: At each strobe where the level sits at the maximum or the minimum, an endstop counter advances, and it clears whenever the level is not at a limit. When the count including the current strobe reaches a nonzero `endstopLimit`, a forced attack fires instead of the normal decision: down by `reactStep` from the maximum, up by `reactStep` from the minimum. The counter then restarts from 0. Setting `endstopLimit` to 0 disables forced attacks.
- R7: All level arithmetic saturates, so that `level` never leaves the range from minimum to maximum.
- R8: The new level appears on the clock edge after the edge that samples `intervalEnd`, together with a one-cycle `levelValid` pulse. At all other times `level` holds its value and `levelValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Domain clock |
| rstN | input | 1 | Asynchronous reset, active low |
| occupancy | input | OCC_W (6) | Current entry count of the domain's input queue |
| intervalEnd | input | 1 | Marks the last cycle of a sampling interval |
| perfLoss | input | PERF_W (8) | Performance loss measured over the last interval |
| devThresh | input | SUM_W (16) | Swing in interval sum needed to trigger an attack |
| reactStep | input | LVL_W (9) | Level change applied by an attack |
| decayStep | input | LVL_W (9) | Level decrease applied by a decay |
| perfThresh | input | PERF_W (8) | A decrease is allowed only while perfLoss is below this value |
| endstopLimit | input | ES_W (4) | Number of consecutive strobes at a limit before a forced attack; 0 disables |
| level | output | LVL_W (9) | Target frequency level index |
| levelValid | output | 1 | One-cycle pulse when a new level is registered |

## Verification
The only register between a strobe and the result is the level register. The new `level` and the `levelValid` pulse are therefore due one clock edge after the edge that samples `intervalEnd`. The bench drives inputs on the falling edge and compares both outputs with its reference model on the next falling edge, which is the first point at which the new value is visible. On every other cycle the bench checks that `level` is unchanged and that `levelValid` is low. Because of this, an update that comes a cycle early or late, or a pulse that is stretched, fails a check in the cycle where the difference appears.

// File: rtl/qgov_pkg.sv
package qgov_pkg;

  // Strobes from the decision logic to the datapath
  typedef struct packed {
    logic latch;     // close the interval: store sum, register level
    logic stepUp;    // add the reaction step
    logic stepDn;    // subtract a step
    logic useDecay;  // subtract the decay step instead of the reaction step
  } govCmd_t;

endpackage

// File: rtl/qgov_datapath.sv
module qgov_datapath
  import qgov_pkg::*;
#(
  parameter int OCC_W   = 6,
  parameter int SUM_W   = 16,
  parameter int LVL_W   = 9,
  parameter int LVL_MAX = 319,
  parameter int LVL_MIN = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OCC_W-1:0] occupancy,
  input  logic [SUM_W-1:0] devThresh,
  input  logic [LVL_W-1:0] reactStep,
  input  logic [LVL_W-1:0] decayStep,
  input  govCmd_t          cmd,
  output logic             riseFlag,
  output logic             fallFlag,
  output logic             atMax,
  output logic             atMin,
  output logic [LVL_W-1:0] level,
  output logic             levelValid
);

  localparam logic [LVL_W-1:0] MAX_L  = LVL_W'(LVL_MAX);
  localparam logic [LVL_W:0]   MAX_WL = (LVL_W+1)'(LVL_MAX);

  logic [SUM_W-1:0] accSum, prevSum, sumNow, riseAmt, fallAmt;
  logic [SUM_W:0]   accWide;
  logic [LVL_W-1:0] stepAmt, lvlUp, lvlDn;
  logic [LVL_W:0]   upWide;

  // Saturating running sum, counting the current cycle
  assign accWide = {1'b0, accSum} + (SUM_W+1)'(occupancy);
  assign sumNow  = accWide[SUM_W] ? '1 : accWide[SUM_W-1:0];

  assign riseAmt  = sumNow - prevSum;
  assign fallAmt  = prevSum - sumNow;
  assign riseFlag = (sumNow > prevSum) && (riseAmt > devThresh);
  assign fallFlag = (prevSum > sumNow) && (fallAmt > devThresh);

  assign stepAmt = cmd.useDecay ? decayStep : reactStep;
  assign upWide  = {1'b0, level} + {1'b0, stepAmt};
  assign lvlUp   = (upWide > MAX_WL) ? MAX_L : upWide[LVL_W-1:0];
  assign atMax   = (level == MAX_L);

  generate
    if (LVL_MIN == 0) begin : g_zeroFloor
      assign lvlDn = (stepAmt > level) ? '0 : level - stepAmt;
      assign atMin = (level == '0);
    end else begin : g_raisedFloor
      logic [LVL_W-1:0] room;
      assign room  = level - LVL_W'(LVL_MIN);
      assign lvlDn = (stepAmt > room) ? LVL_W'(LVL_MIN) : level - stepAmt;
      assign atMin = (level == LVL_W'(LVL_MIN));

      // R7
      floor_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        level >= LVL_W'(LVL_MIN));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accSum     <= '0;
      prevSum    <= '0;
      level      <= MAX_L;
      levelValid <= 1'b0;
    end else begin
      levelValid <= cmd.latch;
      if (cmd.latch) begin
        accSum  <= '0;
        prevSum <= sumNow;
        if (cmd.stepUp)      level <= lvlUp;
        else if (cmd.stepDn) level <= lvlDn;
      end else begin
        accSum <= sumNow;
      end
    end
  end

  // R7
  ceiling_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    level <= MAX_L);

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.latch |=> levelValid);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.latch |=> (!levelValid && $stable(level)));

endmodule

// File: rtl/qgov_decide.sv
module qgov_decide
  import qgov_pkg::*;
#(
  parameter int PERF_W = 8,
  parameter int ES_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intervalEnd,
  input  logic              riseFlag,
  input  logic              fallFlag,
  input  logic              atMax,
  input  logic              atMin,
  input  logic [PERF_W-1:0] perfLoss,
  input  logic [PERF_W-1:0] perfThresh,
  input  logic [ES_W-1:0]   endstopLimit,
  output govCmd_t           cmd
);

  logic [ES_W-1:0] endCnt;
  logic [ES_W:0]   cntPlus;
  logic atLimit, esHit, forced, forcedUp, forcedDn, perfOk;

  assign atLimit  = atMax | atMin;
  assign cntPlus  = {1'b0, endCnt} + (ES_W+1)'(1);
  assign esHit    = (endstopLimit != '0) && (cntPlus >= {1'b0, endstopLimit});
  assign forced   = intervalEnd & atLimit & esHit;
  assign forcedDn = forced & atMax;
  assign forcedUp = forced & ~atMax;
  assign perfOk   = (perfLoss < perfThresh);

  always_comb begin
    cmd.latch    = intervalEnd;
    cmd.stepUp   = forcedUp | (intervalEnd & ~forced & riseFlag);
    cmd.stepDn   = forcedDn | (intervalEnd & ~forced & ~riseFlag & perfOk);
    cmd.useDecay = ~forced & ~riseFlag & ~fallFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      endCnt <= '0;
    end else if (!atLimit) begin
      endCnt <= '0;
    end else if (intervalEnd) begin
      if (forced)           endCnt <= '0;
      else if (endCnt != '1) endCnt <= endCnt + 1'b1;
    end
  end

  // R6
  endstop_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (endstopLimit != '0 && $stable(endstopLimit) && $past(endCnt) < endstopLimit)
      |-> endCnt < endstopLimit);

  // R6
  endstop_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !atLimit |=> endCnt == '0);

endmodule

// File: rtl/qgov_ctrl.sv
module qgov_ctrl
  import qgov_pkg::*;
#(
  parameter int OCC_W   = 6,
  parameter int CNT_W   = 10,
  parameter int PERF_W  = 8,
  parameter int ES_W    = 4,
  parameter int LVL_MAX = 319,
  parameter int LVL_MIN = 0,
  localparam int SUM_W  = OCC_W + CNT_W,
  localparam int LVL_W  = $clog2(LVL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OCC_W-1:0]  occupancy,
  input  logic              intervalEnd,
  input  logic [PERF_W-1:0] perfLoss,
  input  logic [SUM_W-1:0]  devThresh,
  input  logic [LVL_W-1:0]  reactStep,
  input  logic [LVL_W-1:0]  decayStep,
  input  logic [PERF_W-1:0] perfThresh,
  input  logic [ES_W-1:0]   endstopLimit,
  output logic [LVL_W-1:0]  level,
  output logic              levelValid
);

  govCmd_t cmd;
  logic riseFlag, fallFlag, atMax, atMin;

  qgov_decide #(.PERF_W(PERF_W), .ES_W(ES_W)) uDecide (
    .clk(clk), .rstN(rstN), .intervalEnd(intervalEnd),
    .riseFlag(riseFlag), .fallFlag(fallFlag), .atMax(atMax), .atMin(atMin),
    .perfLoss(perfLoss), .perfThresh(perfThresh), .endstopLimit(endstopLimit),
    .cmd(cmd)
  );

  qgov_datapath #(
    .OCC_W(OCC_W), .SUM_W(SUM_W), .LVL_W(LVL_W),
    .LVL_MAX(LVL_MAX), .LVL_MIN(LVL_MIN)
  ) uPath (
    .clk(clk), .rstN(rstN), .occupancy(occupancy), .devThresh(devThresh),
    .reactStep(reactStep), .decayStep(decayStep), .cmd(cmd),
    .riseFlag(riseFlag), .fallFlag(fallFlag), .atMax(atMax), .atMin(atMin),
    .level(level), .levelValid(levelValid)
  );

  // R5
  perf_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intervalEnd && perfLoss >= perfThresh && level != LVL_W'(LVL_MAX))
      |=> level >= $past(level));

endmodule

// File: tb/qgov_ctrl_test.sv
module qgov_ctrl_test;
  localparam int OCC_W = 6, CNT_W = 10, PERF_W = 8, ES_W = 4;
  localparam int LMAX = 319, LMIN = 0;
  localparam int SUM_W = OCC_W + CNT_W;
  localparam int LVL_W = $clog2(LMAX + 1);
  localparam int SUM_CAP = (1 << SUM_W) - 1;
  localparam int CNT_CAP = (1 << ES_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [OCC_W-1:0]  occupancy = '0;
  logic              intervalEnd = 1'b0;
  logic [PERF_W-1:0] perfLoss = '0, perfThresh = '0;
  logic [SUM_W-1:0]  devThresh = '0;
  logic [LVL_W-1:0]  reactStep = '0, decayStep = '0;
  logic [ES_W-1:0]   endstopLimit = '0;
  logic [LVL_W-1:0]  level;
  logic              levelValid;

  always #4 clk = ~clk;

  qgov_ctrl uut (
    .clk(clk), .rstN(rstN), .occupancy(occupancy), .intervalEnd(intervalEnd),
    .perfLoss(perfLoss), .devThresh(devThresh), .reactStep(reactStep),
    .decayStep(decayStep), .perfThresh(perfThresh), .endstopLimit(endstopLimit),
    .level(level), .levelValid(levelValid)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  int mLevel = LMAX, mCnt = 0, mPrev = 0, mAcc = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference decision at a strobe (mAcc already includes the strobe cycle)
  task automatic modelStrobe(output string tag);
    int cur, nl;
    bit atMax, atMin, atLim, perfOk, forced;
    cur    = (mAcc > SUM_CAP) ? SUM_CAP : mAcc;
    atMax  = (mLevel == LMAX);
    atMin  = (mLevel == LMIN);
    atLim  = atMax || atMin;
    perfOk = (int'(perfLoss) < int'(perfThresh));
    forced = atLim && endstopLimit != 0 && (mCnt + 1 >= int'(endstopLimit));
    if (forced) begin
      nl = atMax ? mLevel - int'(reactStep) : mLevel + int'(reactStep);
      tag = "R6 forced";
      mCnt = 0;
    end else begin
      mCnt = atLim ? ((mCnt + 1 > CNT_CAP) ? CNT_CAP : mCnt + 1) : 0;
      if (cur > mPrev && cur - mPrev > int'(devThresh)) begin
        nl = mLevel + int'(reactStep); tag = "R2 attack up";
      end else if (perfOk && mPrev > cur && mPrev - cur > int'(devThresh)) begin
        nl = mLevel - int'(reactStep); tag = "R3 attack down";
      end else if (perfOk) begin
        nl = mLevel - int'(decayStep); tag = "R4 decay";
      end else begin
        nl = mLevel; tag = "R5 gated hold";
      end
    end
    if (nl > LMAX) begin nl = LMAX; tag = {tag, " R7 clamp"}; end
    if (nl < LMIN) begin nl = LMIN; tag = {tag, " R7 clamp"}; end
    mLevel = nl;
    mPrev  = cur;
    mAcc   = 0;
  endtask

  // One interval of len cycles; strobe on the last one. Called at a negedge.
  task automatic runInterval(int len, int occBase, int occSpan);
    for (int i = 0; i < len; i++) begin
      int o;
      string tag;
      o = occBase + ((occSpan > 0) ? int'($urandom_range(occSpan)) : 0);
      if (o > 63) o = 63;
      occupancy   = OCC_W'(o);
      intervalEnd = (i == len - 1);
      mAcc += o;
      tag = "R8 hold";
      if (intervalEnd) modelStrobe(tag);
      @(negedge clk);
      if (i == len - 1) begin
        check(int'(level) == mLevel, tag, int'(level), mLevel);
        check(levelValid == 1'b1, "R8 valid pulse", int'(levelValid), 1);
      end else begin
        check(int'(level) == mLevel, "R8 level hold", int'(level), mLevel);
        check(levelValid == 1'b0, "R8 valid low", int'(levelValid), 0);
      end
      check(int'(level) <= LMAX, "R7 range", int'(level), LMAX);
    end
    intervalEnd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(int'(level) == LMAX, "R1 reset level", int'(level), LMAX);
    check(levelValid == 1'b0, "R1 reset valid", int'(levelValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(int'(level) == LMAX, "R1 level after release", int'(level), LMAX);

    // Directed corners
    devThresh = 50; reactStep = 40; decayStep = 3;
    perfThresh = 10; perfLoss = 20; endstopLimit = 3;
    runInterval(16, 20, 0);   // R2 rise at max -> R7 clamp
    runInterval(16, 20, 0);   // R5 hold at max
    runInterval(16, 20, 0);   // R6 forced down to 279
    check(int'(level) == 279, "R6 forced down from max", int'(level), 279);
    perfLoss = 0;
    runInterval(16, 20, 0);   // R4 decay to 276
    check(int'(level) == 276, "R4 decay step", int'(level), 276);
    runInterval(16, 10, 0);   // R3 fall 160 -> 236
    check(int'(level) == 236, "R3 attack down", int'(level), 236);
    perfLoss = 20;
    runInterval(16, 0, 0);    // R5 fall gated
    check(int'(level) == 236, "R5 gated fall", int'(level), 236);
    perfLoss = 0; decayStep = 300;
    runInterval(4, 0, 0);     // R7 decay clamps at 0
    check(int'(level) == 0, "R7 floor clamp", int'(level), 0);
    decayStep = 3;
    runInterval(4, 0, 0);
    runInterval(4, 0, 0);
    runInterval(4, 0, 0);     // R6 forced up from min
    check(int'(level) == 40, "R6 forced up from min", int'(level), 40);
    runInterval(1, 63, 0);    // R2 single-cycle interval, sum 63 > 50
    check(int'(level) == 80, "R2 one-cycle interval", int'(level), 80);

    // Constrained random phase
    for (int k = 0; k < 300; k++) begin
      if (k % 20 == 0) begin
        devThresh    = SUM_W'($urandom_range(400));
        reactStep    = LVL_W'($urandom_range(120));
        decayStep    = LVL_W'($urandom_range(12));
        perfThresh   = PERF_W'($urandom_range(64));
        endstopLimit = ES_W'($urandom_range(CNT_CAP));
      end
      perfLoss = PERF_W'($urandom_range(80));
      runInterval(int'($urandom_range(1, 40)), int'($urandom_range(40)),
                  int'($urandom_range(23)));
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule